// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of external interrupt lines and routes them to a small number of processor contexts. Each source line passes through a gateway. The gateway is built either for rising edges or for a high level, and it turns that input into a pending bit. It then holds back further requests from that line until software reports the interrupt as handled. Every source has a small priority value. Every context has its own enable mask and its own priority threshold. For each context the core finds the best source that is pending and enabled and whose priority clears the threshold. It drives that context's interrupt line from a register.

Software reaches the core through a plain word-wide register bus with separate read and write strobes. To take an interrupt, software reads the context's claim register. The read returns the winning source ID, or 0 when nothing qualifies, and in the same cycle it clears that source's pending bit. Software writes the same ID back to that register when it has finished. This completion lets the source's gateway raise a new request. Sources are numbered from 1, and ID 0 is reserved to mean "nothing".

Top module: `pic_core`

## Requirements
- R1: After a synchronous reset, every priority, enable and threshold register reads 0, every claim returns 0, and every interrupt output is low.
- R2: The priority of source n is a 3-bit register at byte address n*4, and its upper bits read 0. Writes to the address of ID 0 or of an ID above the source count are dropped, and those addresses read 0.
- R3: The enable mask of context c starts at byte address 0x2000 + c*0x80. Source n is bit (n mod 32) of word (n / 32) in that mask. Bit 0 of word 0 always reads 0.
- R4: The threshold of context c is a 3-bit register at byte address 0x200000 + c*0x1000, and the claim/complete register sits 4 bytes above it. A bus access hits a register only when its address bits [1:0] are zero.
- R5: An interrupt output is high when at least one source is pending, is enabled for that context and has a priority strictly greater than that context's threshold. The output follows its inputs one cycle later, so it rises two cycles after a source line rises.
- R6: A claim read returns the eligible source with the highest priority. When priorities are equal, the lowest ID wins. The read clears that source's pending bit, and read data appears on the cycle after the read strobe.
- R7: A claim read returns 0 and changes no state when no source is eligible for that context.
- R8: A threshold of 7 keeps the context's output low and makes its claim return 0. A source with priority 0 never interrupts any context.
- R9: A source that has been claimed does not become pending again until an ID completion arrives for it. A completion written to a context that does not enable that ID is ignored.
- R10: A level source that is still high after its completion becomes pending again. Sources 8 to 15 are built as edge sources, and an edge source becomes pending only on a low-to-high change of its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | NSRC | Source lines; bit k carries source k+1 |
| irq_o | output | NCTX | Registered interrupt output per context |

## Verification
The assertions assume a few things about the inputs. The read and write strobes are never high in the same cycle. Source lines are already synchronous to clk. Only one claim or completion reaches the core in any cycle. The bench follows these rules: its bus tasks issue one access at a time, it changes source lines only on the falling clock edge, and it drives every access from a single sequential process. The randomized passes hold level sources high only while the bench expects them to be pending. They drop a line before writing that source's completion, so the bench model never has to predict a level source coming back.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ENA_BASE   = 32'h0000_2000;
  localparam int unsigned ENA_STRIDE = 32'h0000_0080;
  localparam int unsigned CTL_BASE   = 32'h0020_0000;
  localparam int unsigned CTL_STRIDE = 32'h0000_1000;
  localparam logic [11:0] THR_OFF    = 12'h000;
  localparam logic [11:0] CLAIM_OFF  = 12'h004;
endpackage

// File: rtl/pic_gateway.sv
module pic_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o
);
  logic prev_q, busy_q, pend_q, req;

  generate
    if (EDGE) begin : g_edge
      assign req = src_i & ~prev_q;
    end else begin : g_level
      assign req = src_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (claim_i) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
      end else begin
        if (done_i) busy_q <= 1'b0;
        if (req && !busy_q && !pend_q) pend_q <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;

  AST_NO_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) !(pend_q && busy_q)) else $error("pending while busy"); // R9
  AST_CLAIM_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst) claim_i |-> pend_q) else $error("claim of idle source"); // R6
  AST_REARM_ON_DONE: assert property (@(posedge clk) disable iff (rst) $fell(busy_q) |-> $past(done_i)) else $error("released without completion"); // R9
endmodule

// File: rtl/pic_select.sv
module pic_select #(
  parameter int NSRC = 31,
  parameter int PW   = 3,
  parameter int ID_W = $clog2(NSRC + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC:0]           pend,
  input  logic [NSRC:0]           en,
  input  logic [NSRC:0][PW-1:0]   prio,
  input  logic [PW-1:0]           thr,
  output logic [ID_W-1:0]         best_id,
  output logic                    irq_q
);
  logic [PW-1:0] best_p;
  logic          any;

  // Scan from the top ID down; ">=" lets a lower ID take over on a tie.
  always_comb begin
    best_id = '0;
    best_p  = '0;
    any     = 1'b0;
    for (int i = NSRC; i >= 0; i--) begin
      if (pend[i] && en[i] && (prio[i] > thr) && (!any || prio[i] >= best_p)) begin
        best_id = ID_W'(i);
        best_p  = prio[i];
        any     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any;
  end

  AST_THR_MAX_MASK: assert property (@(posedge clk) disable iff (rst) (thr == {PW{1'b1}}) |=> !irq_q) else $error("masked context interrupted"); // R8
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int NSRC    = 31,
  parameter int NCTX    = 2,
  parameter int PW      = 3,
  parameter int ADDR_W  = 26,
  parameter int EDGE_LO = 8,
  parameter int EDGE_HI = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W  = $clog2(NSRC + 1);
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam logic [ADDR_W-1:0] ENA_LO = ADDR_W'(ENA_BASE);
  localparam logic [ADDR_W-1:0] ENA_HI = ADDR_W'(ENA_BASE + NCTX * ENA_STRIDE);
  localparam logic [ADDR_W-1:0] CTL_LO = ADDR_W'(CTL_BASE);
  localparam logic [ADDR_W-1:0] CTL_HI = ADDR_W'(CTL_BASE + NCTX * CTL_STRIDE);

  logic [NSRC:0][PW-1:0] prio_q;
  logic [NCTX-1:0][NSRC:0] en_q;
  logic [NCTX-1:0][PW-1:0] thr_q;
  logic [31:0] rdata_q, rd_val;

  logic [NSRC:0] pend_w, claim_vec, done_vec;
  logic [ID_W-1:0] best_id [NCTX];

  // Address decode
  logic aligned, hit_prio, hit_en, hit_ctl;
  logic [9:0] p_id;
  logic [4:0] e_word;
  logic [CTX_W-1:0] e_ctx, c_ctx;
  logic [11:0] c_reg;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign hit_prio = aligned && (bus_addr < ADDR_W'(32'h1000));
  assign hit_en   = aligned && (bus_addr >= ENA_LO) && (bus_addr < ENA_HI);
  assign hit_ctl  = aligned && (bus_addr >= CTL_LO) && (bus_addr < CTL_HI);
  assign p_id     = bus_addr[11:2];
  assign e_word   = 5'((bus_addr - ENA_LO) >> 2);
  assign e_ctx    = CTX_W'((bus_addr - ENA_LO) >> 7);
  assign c_ctx    = CTX_W'((bus_addr - CTL_LO) >> 12);
  assign c_reg    = bus_addr[11:0];

  logic claim_fire, done_fire, thr_sel;
  logic [ID_W-1:0] claim_id;
  assign thr_sel    = hit_ctl && (c_reg == THR_OFF);
  assign claim_fire = bus_rd && hit_ctl && (c_reg == CLAIM_OFF);
  assign done_fire  = bus_wr && hit_ctl && (c_reg == CLAIM_OFF);
  assign claim_id   = best_id[c_ctx];

  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    for (int i = 1; i <= NSRC; i++) begin
      claim_vec[i] = claim_fire && (claim_id == ID_W'(i));
      done_vec[i]  = done_fire && (bus_wdata == 32'(i)) && en_q[c_ctx][i];
    end
  end

  // Gateways, one per real source
  assign pend_w[0] = 1'b0;
  generate
    for (genvar g = 1; g <= NSRC; g++) begin : g_gw
      pic_gateway #(.EDGE((g >= EDGE_LO) && (g <= EDGE_HI))) u_gw (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_in[g-1]),
        .claim_i (claim_vec[g]),
        .done_i  (done_vec[g]),
        .pend_o  (pend_w[g])
      );
    end
  endgenerate

  // Per-context selection and registered interrupt
  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      pic_select #(.NSRC(NSRC), .PW(PW), .ID_W(ID_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend_w),
        .en      (en_q[c]),
        .prio    (prio_q),
        .thr     (thr_q[c]),
        .best_id (best_id[c]),
        .irq_q   (irq_o[c])
      );
    end
  endgenerate

  // Read mux
  always_comb begin
    rd_val = '0;
    if (hit_prio) begin
      for (int i = 1; i <= NSRC; i++)
        if (p_id == 10'(i)) rd_val[PW-1:0] = prio_q[i];
    end else if (hit_en) begin
      for (int s = 1; s <= NSRC; s++)
        if (s / 32 == int'(e_word)) rd_val[s % 32] = en_q[e_ctx][s];
    end else if (thr_sel) begin
      rd_val[PW-1:0] = thr_q[c_ctx];
    end else if (claim_fire) begin
      rd_val[ID_W-1:0] = claim_id;
    end
  end

  // Configuration registers and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_rd) rdata_q <= rd_val;
      if (bus_wr) begin
        if (hit_prio) begin
          for (int i = 1; i <= NSRC; i++)
            if (p_id == 10'(i)) prio_q[i] <= bus_wdata[PW-1:0];
        end
        if (hit_en) begin
          for (int s = 1; s <= NSRC; s++)
            if (s / 32 == int'(e_word)) en_q[e_ctx][s] <= bus_wdata[s % 32];
        end
        if (thr_sel) thr_q[c_ctx] <= bus_wdata[PW-1:0];
      end
    end
  end

  assign bus_rdata = rdata_q;

  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (rst) (claim_fire && claim_id != '0) |=> !pend_w[$past(claim_id)]) else $error("claimed source still pending"); // R6
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr)) else $error("read and write together"); // R4
endmodule

// File: tb/tb_pic_core.sv
module tb_pic_core;
  localparam int NSRC = 31, NCTX = 2, ADDR_W = 26;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic [NCTX-1:0] irq_o;

  pic_core #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_o(irq_o));

  int n_tests = 0, n_fail = 0;
  int m_prio [32];
  bit m_en [2][32];
  int m_thr [2];
  bit m_pend [32];

  function automatic int a_prio(int id); return id * 4; endfunction
  function automatic int a_en(int c); return 32'h2000 + c * 32'h80; endfunction
  function automatic int a_thr(int c); return 32'h200000 + c * 32'h1000; endfunction
  function automatic int a_clm(int c); return 32'h200004 + c * 32'h1000; endfunction

  function automatic int exp_best(int c);
    int b = 0, bp = 0;
    for (int i = 1; i <= 31; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > m_thr[c] && (b == 0 || m_prio[i] > bp)) begin
        b = i; bp = m_prio[i];
      end
    return b;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic bus_write(int addr, int data);
    @(negedge clk); bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(int addr, output int data);
    @(negedge clk); bus_rd = 1'b1; bus_addr = ADDR_W'(addr);
    @(negedge clk); bus_rd = 1'b0; data = int'(bus_rdata);
  endtask

  task automatic set_prio(int id, int p);
    bus_write(a_prio(id), p); m_prio[id] = p & 7;
  endtask
  task automatic set_en(int c, int mask);
    bus_write(a_en(c), mask);
    for (int i = 1; i < 32; i++) m_en[c][i] = mask[i];
  endtask
  task automatic set_thr(int c, int t);
    bus_write(a_thr(c), t); m_thr[c] = t & 7;
  endtask
  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(int c);
    int got, e;
    for (int k = 0; k < 40; k++) begin
      e = exp_best(c);
      bus_read(a_clm(c), got);
      check("R6 claim order", got, e);
      if (got == 0 || got != e) break;
      m_pend[e] = 1'b0;
      src_in[e-1] = 1'b0;
      bus_write(a_clm(c), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin
      m_prio[i] = 0; m_pend[i] = 0; m_en[0][i] = 0; m_en[1][i] = 0;
    end
    m_thr[0] = 0; m_thr[1] = 0;
    settle(3); rst = 1'b0; settle(1);

    // R1 reset state
    check("R1 irq after reset", int'(irq_o), 0);
    bus_read(a_prio(5), v);  check("R1 prio reset", v, 0);
    bus_read(a_en(1), v);    check("R1 enable reset", v, 0);
    bus_read(a_thr(0), v);   check("R1 threshold reset", v, 0);
    bus_read(a_clm(0), v);   check("R7 claim empty after reset", v, 0);

    // R2 priority registers
    set_prio(5, 32'hFFFF_FFFF);
    bus_read(a_prio(5), v);  check("R2 prio width", v, 7);
    bus_write(a_prio(0), 5);
    bus_read(a_prio(0), v);  check("R2 id0 prio", v, 0);
    bus_write(a_prio(32), 5);
    bus_read(a_prio(32), v); check("R2 out of range prio", v, 0);

    // R3 enable layout
    set_en(1, 32'hFFFF_FFFF);
    bus_read(a_en(1), v);    check("R3 enable bit0 reads 0", v, 32'hFFFF_FFFE);
    set_en(0, 32'h24);
    bus_read(a_en(0), v);    check("R3 enable ctx0", v, 32'h24);
    set_en(1, 0);

    // R4 threshold and alignment
    set_thr(1, 32'hFF);
    bus_read(a_thr(1), v);   check("R4 threshold width", v, 7);
    bus_write(a_thr(1) + 1, 3);
    bus_read(a_thr(1), v);   check("R4 unaligned write dropped", v, 7);
    set_thr(1, 0);

    // R5/R6/R7/R9/R10 directed on sources 2 and 5
    set_prio(2, 3); set_prio(5, 3);
    @(negedge clk); src_in[1] = 1'b1; src_in[4] = 1'b1;
    m_pend[2] = 1; m_pend[5] = 1;
    @(negedge clk); check("R5 irq latency one", int'(irq_o[0]), 0);
    @(negedge clk); check("R5 irq latency two", int'(irq_o[0]), 1);
    bus_read(a_clm(0), v);   check("R6 tie lowest id", v, 2);
    bus_read(a_clm(0), v);   check("R6 second claim", v, 5);
    bus_read(a_clm(0), v);   check("R7 nothing left", v, 0);
    m_pend[2] = 0; m_pend[5] = 0;
    bus_write(a_clm(1), 2);  settle(2);
    bus_read(a_clm(0), v);   check("R9 foreign completion ignored", v, 0);
    bus_write(a_clm(0), 2);  settle(2);
    bus_read(a_clm(0), v);   check("R10 level re-pend", v, 2);
    @(negedge clk); src_in[1] = 1'b0; src_in[4] = 1'b0;
    bus_write(a_clm(0), 2);  bus_write(a_clm(0), 5); settle(2);
    bus_read(a_clm(0), v);   check("R9 released and quiet", v, 0);

    // R8 threshold 7 and priority 0
    set_thr(0, 7);
    @(negedge clk); src_in[4] = 1'b1; m_pend[5] = 1;
    settle(3);
    check("R8 thr7 masks irq", int'(irq_o[0]), 0);
    bus_read(a_clm(0), v);   check("R8 thr7 claim", v, 0);
    set_thr(0, 0); settle(2);
    check("R8 thr0 allows irq", int'(irq_o[0]), 1);
    drain(0);
    set_prio(2, 0);
    @(negedge clk); src_in[1] = 1'b1; m_pend[2] = 1;
    settle(3);
    check("R8 prio0 silent", int'(irq_o[0]), 0);
    bus_read(a_clm(0), v);   check("R8 prio0 claim", v, 0);
    set_prio(2, 1);
    drain(0);

    // R10 edge sources on context 1
    set_prio(9, 4); set_prio(10, 2); set_en(1, (1 << 9) | (1 << 10));
    @(negedge clk); src_in[8] = 1'b1;
    @(negedge clk); src_in[8] = 1'b0;
    settle(2);
    check("R10 edge pulse irq", int'(irq_o[1]), 1);
    bus_read(a_clm(1), v);   check("R10 edge claim", v, 9);
    bus_write(a_clm(1), 9);
    @(negedge clk); src_in[9] = 1'b1;
    settle(2);
    bus_read(a_clm(1), v);   check("R10 edge held claim", v, 10);
    bus_write(a_clm(1), 10); settle(3);
    bus_read(a_clm(1), v);   check("R10 held edge no re-pend", v, 0);
    check("R10 held edge irq low", int'(irq_o[1]), 0);
    @(negedge clk); src_in[9] = 1'b0;

    // Random passes on level sources
    for (int it = 0; it < 40; it++) begin
      int lvl;
      for (int id = 1; id <= 31; id++) set_prio(id, int'($urandom % 8));
      for (int c = 0; c < 2; c++) begin
        set_en(c, int'($urandom) & ~1);
        set_thr(c, int'($urandom % 4));
      end
      lvl = int'($urandom) & ~32'h0000_FF01;
      @(negedge clk);
      for (int id = 1; id <= 31; id++)
        if (lvl[id]) begin src_in[id-1] = 1'b1; m_pend[id] = 1; end
      settle(3);
      for (int c = 0; c < 2; c++)
        check("R5 random irq", int'(irq_o[c]), int'(exp_best(c) != 0));
      drain(0);
      drain(1);
      @(negedge clk); src_in = '0;
      for (int id = 1; id <= 31; id++) if (m_pend[id]) set_prio(id, 7);
      set_en(0, 32'hFFFF_FFFE); set_thr(0, 0);
      drain(0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule